// File: doc/BRIEF.md
# Nibble-Coded Register Command Decoder

This block sits behind a byte-wide host command link and gives the host access to a bank of byte-wide registers. Each command byte holds an opcode in its high nibble and a four-bit operand in its low nibble. A register address is assembled from two address-nibble commands. A data byte is assembled from a low-nibble latch command followed by a high-nibble command, and the high-nibble command also performs the write.

A read command returns the addressed byte on a valid/ready output stream. Its operand can step the address up or down after the access, so a run of identical read commands fetches neighbouring registers in a burst. One example is reading two 24-bit counters, least significant byte first.

Command bytes whose opcode the decoder does not handle are passed out unchanged on a side port. Other consumers of the command stream can pick them up there.

Top module: `nibble_cmd_regs`

## Requirements
- R1: Bits 7:4 of a command byte are the opcode and bits 3:0 are the operand. Opcode 0 writes the operand into address bits 3:0. Opcode 1 writes it into address bits 7:4. The other address nibble is unchanged in both cases.
- R2: Opcode 2 stores the operand as the low data nibble. Opcode 3 writes {operand, stored low nibble} into the register at the current address.
- R3: Opcode 4 presents the register at the current address on `rd_data` with `rd_valid` high, starting the cycle after the command is accepted. Both hold unchanged until a cycle with `rd_ready` high.
- R4: In an opcode-4 command, operand bit 0 = 1 changes the address after the read and bit 0 = 0 leaves it as it is. When the address changes, operand bit 1 = 1 decrements it and bit 1 = 0 increments it.
- R5: Address increment and decrement wrap modulo 256: 0xFF+1 gives 0x00 and 0x00-1 gives 0xFF.
- R6: While `rd_valid` is high, `cmd_ready` is low. No command is taken and the address does not change.
- R7: A command with opcode 5 to 15 appears on `side_byte` with `side_valid` high for exactly the one cycle after acceptance. It changes neither the address, the data latch nor any register.
- R8: Reset clears the address, the low data latch, every register, `rd_valid` and `side_valid`.
- R9: Six read commands with operand 0x1 from address A return the registers A to A+5 in ascending order. Read as two 24-bit values, least significant byte first, they give the bytes at A..A+2 and at A+3..A+5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_byte | input | 8 | Command: opcode in 7:4, operand in 3:0 |
| cmd_ready | output | 1 | Decoder can take a command |
| rd_valid | output | 1 | Read byte present |
| rd_data | output | 8 | Read byte |
| rd_ready | input | 1 | Host takes the read byte |
| side_valid | output | 1 | One-cycle pulse for a forwarded command |
| side_byte | output | 8 | Forwarded command byte |

## Verification
The bench uses the default nibble width of 4, which gives the full 8-bit address and a 256-entry register bank. With this width both wrap points (0xFF to 0x00 on increment, 0x00 to 0xFF on decrement) can be reached with a few commands. A stalled read is held for several cycles while a command waits, to show that intake is blocked and the address does not move. Forwarded opcodes are placed between a latch command and its commit to show they disturb nothing.

// File: rtl/nibble_cmd_regs.sv
module nibble_cmd_regs #(
  parameter int NIB = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2*NIB-1:0]     cmd_byte,
  output logic                 cmd_ready,
  output logic                 rd_valid,
  output logic [2*NIB-1:0]     rd_data,
  input  logic                 rd_ready,
  output logic                 side_valid,
  output logic [2*NIB-1:0]     side_byte
);
  localparam int BW    = 2 * NIB;
  localparam int DEPTH = 1 << BW;

  logic [BW-1:0]  addr;
  logic [NIB-1:0] lo_nib;
  logic [BW-1:0]  bank [DEPTH];

  wire            take  = cmd_valid && cmd_ready;
  wire [NIB-1:0]  op    = cmd_byte[BW-1:NIB];
  wire [NIB-1:0]  arg   = cmd_byte[NIB-1:0];
  wire            known = op <= NIB'(4);

  assign cmd_ready = !rd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr       <= '0;
      lo_nib     <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      side_valid <= 1'b0;
      side_byte  <= '0;
      for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
    end else begin
      side_valid <= 1'b0;
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      if (take) begin
        case (op)
          NIB'(0): addr[NIB-1:0]  <= arg;
          NIB'(1): addr[BW-1:NIB] <= arg;
          NIB'(2): lo_nib         <= arg;
          NIB'(3): bank[addr]     <= {arg, lo_nib};
          NIB'(4): begin
            rd_data  <= bank[addr];
            rd_valid <= 1'b1;
            if (arg[0]) addr <= arg[1] ? addr - 1'b1 : addr + 1'b1;
          end
          default: begin
            side_valid <= 1'b1;
            side_byte  <= cmd_byte;
          end
        endcase
      end
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R3
  AST_RD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(cmd_valid && op == NIB'(4))); // R3
  AST_STALL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> $stable(addr)); // R6
  AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    take && op == NIB'(4) && arg[1:0] == 2'b01 |=> addr == BW'($past(addr) + 1)); // R5
  AST_DEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    take && op == NIB'(4) && arg[1:0] == 2'b11 |=> addr == BW'($past(addr) - 1)); // R4
  AST_SIDE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    side_valid |-> $past(cmd_valid && !known)); // R7
  AST_SIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    take && !known |=> $stable(addr) && $stable(lo_nib)); // R7
endmodule

// File: tb/tb_nibble_cmd_regs.sv
`timescale 1ns/1ps
module tb_nibble_cmd_regs;
  logic clk = 0, rst_n = 0, cmd_valid = 0, rd_ready = 0;
  logic [7:0] cmd_byte = 0;
  logic cmd_ready, rd_valid, side_valid;
  logic [7:0] rd_data, side_byte;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  nibble_cmd_regs dut (.clk, .rst_n, .cmd_valid, .cmd_byte, .cmd_ready,
    .rd_valid, .rd_data, .rd_ready, .side_valid, .side_byte);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1; cmd_byte = b;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic set_addr(logic [7:0] a);
    send({4'h0, a[3:0]});
    send({4'h1, a[7:4]});
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    set_addr(a);
    send({4'h2, d[3:0]});
    send({4'h3, d[7:4]});
  endtask

  task automatic rd_expect(logic [3:0] arg, logic [7:0] exp, string tag, output logic [7:0] got);
    send({4'h4, arg});
    check({tag, " valid"}, rd_valid, 1);
    check({tag, " data"}, rd_data, exp);
    got = rd_data;
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
    check({tag, " released"}, rd_valid, 0);
  endtask

  task automatic t_reset;
    logic [7:0] g;
    check("R8 rd_valid", rd_valid, 0);
    check("R8 side_valid", side_valid, 0);
    check("R8 cmd_ready", cmd_ready, 1);
    send(8'h37);
    rd_expect(4'h0, 8'h70, "R8 latch and addr cleared", g);
    set_addr(8'h5A);
    rd_expect(4'h0, 8'h00, "R8 register cleared", g);
  endtask

  task automatic t_nibbles;
    logic [7:0] g;
    wr(8'hC3, 8'hA5);
    wr(8'hC7, 8'h5E);
    wr(8'h93, 8'h1F);
    set_addr(8'hC3);
    rd_expect(4'h0, 8'hA5, "R2 write/read C3", g);
    send(8'h07);
    rd_expect(4'h0, 8'h5E, "R1 low nibble keeps high", g);
    send(8'h19);
    send(8'h03);
    rd_expect(4'h0, 8'h1F, "R1 high nibble keeps low", g);
  endtask

  task automatic t_adjust;
    logic [7:0] g;
    wr(8'h40, 8'h01); wr(8'h41, 8'h02); wr(8'h42, 8'h03);
    set_addr(8'h41);
    rd_expect(4'h0, 8'h02, "R4 no adjust", g);
    rd_expect(4'h2, 8'h02, "R4 bit1 alone no adjust", g);
    rd_expect(4'h3, 8'h02, "R4 decrement", g);
    rd_expect(4'h1, 8'h01, "R4 after decrement", g);
    rd_expect(4'h0, 8'h02, "R4 after increment", g);
  endtask

  task automatic t_wrap;
    logic [7:0] g;
    wr(8'hFF, 8'hAB);
    wr(8'h00, 8'hCD);
    set_addr(8'hFF);
    rd_expect(4'h1, 8'hAB, "R5 read FF", g);
    rd_expect(4'h3, 8'hCD, "R5 inc wrap to 00", g);
    rd_expect(4'h0, 8'hAB, "R5 dec wrap to FF", g);
  endtask

  task automatic t_stall;
    logic [7:0] g;
    wr(8'h30, 8'h77);
    wr(8'h3F, 8'h99);
    set_addr(8'h30);
    send(8'h40);
    @(negedge clk);
    cmd_valid = 1; cmd_byte = 8'h0F;
    for (int i = 0; i < 3; i++) begin
      check("R6 cmd_ready low", cmd_ready, 0);
      check("R6 data held", rd_data, 8'h77);
      check("R6 valid held", rd_valid, 1);
      @(negedge clk);
    end
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
    check("R6 ready back", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 0;
    rd_expect(4'h0, 8'h99, "R6 held command applied after", g);
  endtask

  task automatic t_side;
    logic [7:0] g;
    set_addr(8'h10);
    send(8'h22);
    @(negedge clk);
    cmd_valid = 1; cmd_byte = 8'h5A;
    @(negedge clk);
    cmd_valid = 0;
    check("R7 side pulse", side_valid, 1);
    check("R7 side byte", side_byte, 8'h5A);
    @(negedge clk);
    check("R7 pulse one cycle", side_valid, 0);
    send(8'hF1);
    check("R7 side byte F1", side_byte, 8'hF1);
    send(8'h97);
    send(8'h33);
    rd_expect(4'h0, 8'h32, "R7 no state change", g);
    check("R7 no read from side", rd_valid, 0);
  endtask

  task automatic t_burst;
    logic [7:0] b [6];
    logic [7:0] pat [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    for (int i = 0; i < 6; i++) wr(8'h20 + 8'(i), pat[i]);
    set_addr(8'h20);
    for (int i = 0; i < 6; i++) rd_expect(4'h1, pat[i], "R9 burst byte", b[i]);
    check("R9 first counter", {b[2], b[1], b[0]}, 32'h332211);
    check("R9 second counter", {b[5], b[4], b[3]}, 32'h665544);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_nibbles();
    t_adjust();
    t_wrap();
    t_stall();
    t_side();
    t_burst();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule